// File: doc/BRIEF.md
# Bitstream Mean-Square Density Estimator

This block takes two single-bit streams, each a density code of the same analog quantity produced by a first-order delta-sigma modulator. A high bit means plus full scale and a low bit means minus full scale, so a value A in the range -F..+F appears as a stream whose fraction of high bits is (A + F) / (2F). The two modulators sample at different rates: the fast stream is taken every clock, and the slow stream only on every second clock. Because of the rate difference the streams are uncorrelated. Under that condition the XNOR of the two bits is a stream whose density codes the product of the two values, which here is the square of the input.

The block counts the high product bits over a window of N clocks, where N is a power of two. At the end of each window it presents the raw count and the signed bipolar value 2·count − N, and it raises a one-cycle valid strobe. A window of N clocks resolves the mean square to one part in N. A square root turns the result into RMS, but that step is left to whatever consumes the result. The block drives a slow-rate tick so that the slow modulator can update on the cycles where its bit is captured.

Top module: `msq_density_est`

## Requirements
- R1: The product bit is the XNOR of the held fast bit and the held slow bit. Equal inputs give 1 and unequal inputs give 0. With constant inputs, a window counts N when the two inputs are equal and 0 when they differ.
- R2: `slow_tick` is high on exactly one clock in every two. `slow_bit` is captured only on a rising clock edge where `slow_tick` is high, and the captured value is held otherwise, so changes on other cycles have no effect.
- R3: `fast_bit` is captured on every rising clock edge. A fast stream alternating 1,0,1,0 against a constant slow 1 gives exactly N/2 per window.
- R4: `result_valid` is a one-cycle pulse that repeats exactly every N = 2^WIN_LOG2 clocks. Windows follow each other with no dead cycles.
- R5: `count_out` is WIN_LOG2+1 bits wide. A window in which every product bit is high reports N with no wrap.
- R6: `result` is the signed two's-complement value 2·count − N, WIN_LOG2+2 bits wide, ranging from −N to +N.
- R7: A synchronous active-high `rst` clears the window position, the running count, the held stream bits, `count_out`, `result` and `result_valid`.
- R8: When both streams come from first-order modulators fed the same DC value x (a fraction of full scale) at the 1:2 rates, result/N lies within 1/4 of x².

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fast_bit | input | 1 | Density stream sampled every clock |
| slow_bit | input | 1 | Density stream sampled on `slow_tick` cycles |
| slow_tick | output | 1 | High on the cycle whose rising edge captures `slow_bit` |
| count_out | output | WIN_LOG2+1 | Product ones counted in the last window |
| result | output | WIN_LOG2+2 | Signed mean-square value 2·count − N |
| result_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The last product bit of a window and the clearing of the running count for the next window happen on the same clock edge. An error there either drops that bit or carries it into the next window. The bench provokes this with an all-agree window, which must read exactly N, and with an alternating fast stream, which must read exactly N/2 in every window. It also measures the spacing between strobes. Any lost or duplicated bit at the boundary moves these exact values, so each window is judged by exact equality rather than by a tolerance.

// File: rtl/msq_pkg.sv
package msq_pkg;
  // Bipolar mapping of a ones count in a window of n clocks.
  function automatic int to_bipolar(input int cnt, input int n);
    return 2 * cnt - n;
  endfunction

  // Window length from its log2.
  function automatic int win_len(input int lg);
    return 1 << lg;
  endfunction
endpackage

// File: rtl/msq_rate_gen.sv
module msq_rate_gen #(
  parameter int RATIO = 2
) (
  input  logic clk,
  input  logic rst,
  output logic slow_en
);
  localparam int PH_W = (RATIO > 2) ? $clog2(RATIO) : 1;

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= '0;
    else if (phase == PH_W'(RATIO - 1)) phase <= '0;
    else phase <= phase + 1'b1;
  end

  assign slow_en = (phase == '0);

  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    slow_en |=> !slow_en);
endmodule

// File: rtl/msq_stream_mult.sv
module msq_stream_mult (
  input  logic clk,
  input  logic rst,
  input  logic fast_in,
  input  logic slow_in,
  input  logic slow_en,
  output logic prod
);
  logic fast_q;
  logic slow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_q <= 1'b0;
      slow_q <= 1'b0;
    end else begin
      fast_q <= fast_in;
      if (slow_en) slow_q <= slow_in;
    end
  end

  // Single-bit multiplier for bipolar codes.
  assign prod = ~(fast_q ^ slow_q);

  a_r2_slow_hold: assert property (@(posedge clk) disable iff (rst)
    !slow_en |=> $stable(slow_q));
  a_r3_fast_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (fast_q == $past(fast_in)));
endmodule

// File: rtl/msq_window_acc.sv
module msq_window_acc #(
  parameter int WIN_LOG2 = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       prod,
  output logic [WIN_LOG2:0]          count_q,
  output logic signed [WIN_LOG2+1:0] result_q,
  output logic                       valid_q,
  output logic                       win_end
);
  localparam int N     = msq_pkg::win_len(WIN_LOG2);
  localparam int CNT_W = WIN_LOG2 + 1;
  localparam int RES_W = WIN_LOG2 + 2;

  logic [WIN_LOG2-1:0] pos;
  logic [CNT_W-1:0]    acc;
  logic [CNT_W-1:0]    total;

  assign win_end = (pos == {WIN_LOG2{1'b1}});
  assign total   = acc + {{WIN_LOG2{1'b0}}, prod};

  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= '0;
      acc      <= '0;
      count_q  <= '0;
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      pos     <= pos + 1'b1;
      valid_q <= win_end;
      if (win_end) begin
        count_q  <= total;
        result_q <= RES_W'(msq_pkg::to_bipolar(int'(total), N));
        acc      <= '0;
      end else begin
        acc <= total;
      end
    end
  end

  a_r4_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> !valid_q);
  a_r4_valid_after_end: assert property (@(posedge clk) disable iff (rst)
    win_end |=> valid_q);
  a_r4_restart_clean: assert property (@(posedge clk) disable iff (rst)
    win_end |=> (acc == '0));
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (count_q <= CNT_W'(N)));
  a_r6_sign_match: assert property (@(posedge clk) disable iff (rst)
    valid_q |-> (result_q[RES_W-1] == (count_q < CNT_W'(N / 2))));
endmodule

// File: rtl/msq_density_est.sv
module msq_density_est #(
  parameter int WIN_LOG2   = 8,
  parameter int SLOW_RATIO = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       fast_bit,
  input  logic                       slow_bit,
  output logic                       slow_tick,
  output logic [WIN_LOG2:0]          count_out,
  output logic signed [WIN_LOG2+1:0] result,
  output logic                       result_valid
);
  logic slow_en;
  logic prod;
  logic win_end;

  msq_rate_gen #(.RATIO(SLOW_RATIO)) rate_i (
    .clk(clk), .rst(rst), .slow_en(slow_en)
  );

  msq_stream_mult mult_i (
    .clk(clk), .rst(rst), .fast_in(fast_bit), .slow_in(slow_bit),
    .slow_en(slow_en), .prod(prod)
  );

  msq_window_acc #(.WIN_LOG2(WIN_LOG2)) acc_i (
    .clk(clk), .rst(rst), .prod(prod), .count_q(count_out),
    .result_q(result), .valid_q(result_valid), .win_end(win_end)
  );

  assign slow_tick = slow_en;

  a_r7_reset_clear: assert property (@(posedge clk)
    rst |=> (!result_valid && count_out == '0 && result == '0));
endmodule

// File: tb/msq_density_est_tb_top.sv
module msq_density_est_tb_top;
  localparam int WL = 8;
  localparam int N  = 1 << WL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fast_bit = 1'b0;
  logic slow_bit = 1'b0;
  logic slow_tick;
  logic [WL:0] count_out;
  logic signed [WL+1:0] result;
  logic result_valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic done = 1'b0;

  msq_density_est #(.WIN_LOG2(WL), .SLOW_RATIO(2)) dut_i (
    .clk(clk), .rst(rst), .fast_bit(fast_bit), .slow_bit(slow_bit),
    .slow_tick(slow_tick), .count_out(count_out), .result(result),
    .result_valid(result_valid)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      fails  = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_tol(input string req, input int act, input int exp, input int tol);
    checks = checks + 1;
    if (act > exp + tol || act < exp - tol) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d +/- %0d", req, act, exp, tol);
    end
  endtask

  // mode 0: constants fv/sv; 1: fast alternates, slow 1; 2: slow changes
  // only off-tick; 3: dithered first-order modulators at input xi/64.
  task automatic run_mode(input int mode, input int fv, input int sv, input int xi,
                          input int nwin, output int cnt, output int res,
                          output int gap, output int wide);
    int nv = 0;
    int last = -1;
    int accf = 0;
    int accs = 0;
    logic [15:0] lf = 16'hACE1;
    logic [15:0] ls = 16'h1D35;
    cnt = -1; res = 0; gap = 0; wide = 0;
    for (int i = 0; i < nwin * N * 2 + 64; i++) begin
      @(negedge clk);
      if (result_valid) begin
        nv++;
        if (last >= 0) gap = i - last;
        last = i;
        if (nv == nwin) begin
          cnt = int'(count_out);
          res = int'(result);
          @(negedge clk);
          wide = result_valid ? 1 : 0;
          return;
        end
      end
      case (mode)
        0: begin fast_bit = fv[0]; slow_bit = sv[0]; end
        1: begin fast_bit = ~fast_bit; slow_bit = 1'b1; end
        2: begin fast_bit = 1'b1; slow_bit = slow_tick; end
        default: begin
          int d;
          lf = lf[0] ? ((lf >> 1) ^ 16'hB400) : (lf >> 1);
          d = int'(lf[6:0]) - 64;
          fast_bit = (accf + d) >= 0;
          accf = accf + xi - (fast_bit ? 64 : -64);
          if (slow_tick) begin
            ls = ls[0] ? ((ls >> 1) ^ 16'hB400) : (ls >> 1);
            d = int'(ls[6:0]) - 64;
            slow_bit = (accs + d) >= 0;
            accs = accs + xi - (slow_bit ? 64 : -64);
          end
        end
      endcase
    end
  endtask

  initial begin
    int c, r, g, w;
    int xs[5] = '{64, -64, 0, 32, -32};
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7 valid in reset", int'(result_valid), 0);
    chk("R7 count in reset", int'(count_out), 0);
    chk("R7 result in reset", int'(result), 0);
    rst = 1'b0;

    // R1, R5, R6: constant pairs
    for (int p = 0; p < 4; p++) begin
      int f = p >> 1;
      int s = p & 1;
      run_mode(0, f, s, 0, 3, c, r, g, w);
      chk("R1 constant pair count", c, (f == s) ? N : 0);
      chk("R6 constant pair result", r, (f == s) ? N : -N);
      chk("R4 window spacing", g, N);
      chk("R4 strobe width", w, 0);
    end
    chk("R5 all-agree count not wrapped", c, N);

    // R3: alternating fast stream
    run_mode(1, 0, 0, 0, 3, c, r, g, w);
    chk("R3 alternating fast count", c, N / 2);
    chk("R6 alternating fast result", r, 0);

    // R2: slow stream changes only when not captured
    run_mode(2, 0, 0, 0, 3, c, r, g, w);
    chk("R2 off-tick changes ignored", c, N);

    // R2: tick spacing
    begin
      int prev;
      int bad = 0;
      @(negedge clk);
      prev = int'(slow_tick);
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        if (int'(slow_tick) == prev) bad++;
        prev = int'(slow_tick);
      end
      chk("R2 tick alternates", bad, 0);
    end

    // R7: mid-window reset, then first window from reset
    @(negedge clk); fast_bit = 1'b1; slow_bit = 1'b1; rst = 1'b1;
    @(negedge clk);
    chk("R7 valid after reset", int'(result_valid), 0);
    chk("R7 count after reset", int'(count_out), 0);
    rst = 1'b0;
    run_mode(0, 1, 1, 0, 1, c, r, g, w);
    chk("R7 first window after reset", c, N);

    // R8: mean square from modulators
    foreach (xs[k]) begin
      run_mode(3, 0, 0, xs[k], 3, c, r, g, w);
      chk_tol("R8 mean square", r, (xs[k] * xs[k] * N) / 4096, N / 4);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule